// File: doc/BRIEF.md
# Serial Pattern Error Checker with Fault Classification

This block takes a serial stream from a device under test at one bit per clock, qualified by a valid strobe. It compares every bit with a reference that it produces locally. The reference is either a 31-stage pseudo-random sequence that the block re-creates from the incoming data, or a user pattern of up to 1024 bits held in a small bit-addressable store. After a hunt phase the checker declares lock. From then on it counts compared bits and mismatches.

Each mismatch is also classified. Two or more back-to-back errors form a burst. Errors that land at one fixed spacing several times in a row are flagged as periodic, and the spacing is reported. A lone error with no regular spacing behind it counts as random. These classes let a test station tell a systematic defect apart from background noise. A run can be limited to a programmed number of full pattern passes. The counters can be read at any time while the comparison continues.

Top module: `prbs_err_classifier`

## Requirements
- R1: `err_bit` is 1 in the cycle after a compare made while locked and not done, if the received bit differs from the reference bit. Otherwise it is 0.
- R2: When `cfg_mem_mode` is 0, the first 31 valid bits seed the reference. Each later bit n is predicted as b[n-31] XOR b[n-28]. During hunt the received bit is shifted into the reference. `locked` rises after 64 consecutive correct predictions, so it is 0 after 94 valid bits of a clean sequence and 1 after 95.
- R3: When `cfg_mem_mode` is 1, the reference is pattern bit `pos`, where bit `a` is written through `pat_we`/`pat_addr`/`pat_wbit`. `pos` starts at 0 and wraps to 0 after `cfg_pat_len`-1. `locked` rises after 64 consecutive matches: it is 0 after 63 aligned bits and 1 after 64.
- R4: `bit_cnt` counts compares and `err_cnt` counts mismatches, but only for compares made while locked and not done.
- R5: A mismatch that directly follows a mismatch, where the compare before that one matched, increments `burst_cnt` once and sets the sticky `burst_flag`.
- R6: An error is random when the compares on both sides of it match, unless the interval from the previous error is at least 2 and equals the interval between the two errors before it. Each random error increments `rand_cnt`, counted when the following compare arrives.
- R7: When the number of consecutive equal error-to-error intervals of at least 2 reaches K, the sticky `per_flag` is set and `per_gap` holds that interval. K is `cfg_per_k`; the value 0 means 3.
- R8: A pass completes on each locked compare at the last pattern position. This position is `cfg_pat_len`-1 in pattern mode, or the sequence period minus 1 in pseudo-random mode, counted from lock. `pass_cnt` counts the completed passes. When it reaches a non-zero `cfg_passes`, `done` is set and later bits change no counter. `cfg_passes` of 0 means the run never ends.
- R9: All counters saturate at their maximum value instead of wrapping.
- R10: `clr` resets all counters, flags, `done`, `locked` and the seeding state in the next cycle. It leaves the pattern store unchanged.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of run state |
| in_vld | input | 1 | Received bit is valid |
| in_bit | input | 1 | Received bit |
| cfg_mem_mode | input | 1 | 1: user pattern reference, 0: pseudo-random reference |
| cfg_pat_len | input | AW+1 | User pattern length, 1..DEPTH |
| cfg_per_k | input | K_W | Equal intervals needed for the periodic flag, 0 means 3 |
| cfg_passes | input | PASS_W | Passes per run, 0 means unlimited |
| pat_we | input | 1 | Pattern store write enable |
| pat_addr | input | AW | Pattern store bit address |
| pat_wbit | input | 1 | Pattern bit to write |
| err_bit | output | 1 | Per-bit mismatch indication |
| locked | output | 1 | Reference aligned, counting active |
| done | output | 1 | Programmed passes completed |
| bit_cnt | output | BIT_W | Compared bits |
| err_cnt | output | ERR_W | Mismatched bits |
| rand_cnt | output | ERR_W | Random isolated errors |
| burst_cnt | output | ERR_W | Error bursts |
| burst_flag | output | 1 | Sticky burst fault |
| per_flag | output | 1 | Sticky periodic fault |
| per_gap | output | BIT_W | Detected periodic spacing |
| pass_cnt | output | PASS_W | Completed passes |

## Verification
The end of a run and the classification of an error can fall on the same compare. This happens when the last position of the final pass is itself a mismatch, or even the second bit of a burst. The bench provokes this in pattern mode by flipping the final two bits of the last pass. It then expects two counted errors, one burst, no random error and `done` high. It also expects that the bits sent afterwards leave every counter unchanged. Random trials in the pseudo-random mode put errors at bench-chosen positions, and the bench derives the burst, random and periodic results from that error map alone.

// File: rtl/prbs_err_classifier.sv
module prbs_err_classifier #(
  parameter int DEPTH = 1024,
  parameter int BIT_W = 48,
  parameter int ERR_W = 32,
  parameter int PASS_W = 10,
  parameter int K_W = 4,
  parameter int LOCK_RUN = 64,
  parameter int unsigned PRBS_PERIOD = 32'h7FFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_vld,
  input  logic              in_bit,
  input  logic              cfg_mem_mode,
  input  logic [$clog2(DEPTH):0]   cfg_pat_len,
  input  logic [K_W-1:0]    cfg_per_k,
  input  logic [PASS_W-1:0] cfg_passes,
  input  logic              pat_we,
  input  logic [$clog2(DEPTH)-1:0] pat_addr,
  input  logic              pat_wbit,
  output logic              err_bit,
  output logic              locked,
  output logic              done,
  output logic [BIT_W-1:0]  bit_cnt,
  output logic [ERR_W-1:0]  err_cnt,
  output logic [ERR_W-1:0]  rand_cnt,
  output logic [ERR_W-1:0]  burst_cnt,
  output logic              burst_flag,
  output logic              per_flag,
  output logic [BIT_W-1:0]  per_gap,
  output logic [PASS_W-1:0] pass_cnt
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;
  localparam int RUN_W = $clog2(LOCK_RUN + 1);

  logic [DEPTH-1:0] mem;
  logic [30:0] lfsr;
  logic [4:0] seed_n;
  logic seeded;
  logic [RUN_W-1:0] run;
  logic [31:0] pos;
  logic e1, e2, sp1, have_err;
  logic [BIT_W-1:0] last_idx, last_gap;
  logic [K_W-1:0] streak;

  always_ff @(posedge clk) if (pat_we) mem[pat_addr] <= pat_wbit;

  wire prbs_ref = lfsr[30] ^ lfsr[27];
  wire ref_bit  = cfg_mem_mode ? mem[pos[AW-1:0]] : prbs_ref;
  wire miss     = in_bit ^ ref_bit;
  wire cmp      = in_vld && locked && !done;
  wire hunt     = in_vld && !locked && (cfg_mem_mode || seeded);
  wire seeding  = in_vld && !locked && !cfg_mem_mode && !seeded;
  wire [K_W-1:0] k_eff = (cfg_per_k == '0) ? K_W'(3) : cfg_per_k;
  wire [31:0] len32 = {{(32-LW){1'b0}}, cfg_pat_len};
  wire at_last  = cfg_mem_mode ? (pos == len32 - 32'd1) : (pos == PRBS_PERIOD - 32'd1);
  wire [31:0] pos_next = at_last ? 32'd0 : pos + 32'd1;
  wire [BIT_W-1:0] gap = bit_cnt - last_idx;
  wire gap_ok   = have_err && (gap >= BIT_W'(2));
  wire same     = gap_ok && (gap == last_gap);
  wire [K_W-1:0] new_streak = same ? ((&streak) ? streak : streak + K_W'(1))
                                   : (gap_ok ? K_W'(1) : K_W'(0));
  wire run_full = (run + RUN_W'(1)) == RUN_W'(LOCK_RUN);
  wire m0       = (in_bit == mem[0]);
  wire burst_hit = miss && e1 && !e2;
  wire rand_hit  = e1 && !e2 && !miss && !sp1;
  wire per_hit   = miss && gap_ok && (new_streak >= k_eff) && !per_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr <= '0; seed_n <= '0; seeded <= 1'b0; run <= '0; pos <= '0;
      locked <= 1'b0; done <= 1'b0; err_bit <= 1'b0;
      bit_cnt <= '0; err_cnt <= '0; rand_cnt <= '0; burst_cnt <= '0;
      burst_flag <= 1'b0; per_flag <= 1'b0; per_gap <= '0; pass_cnt <= '0;
      e1 <= 1'b0; e2 <= 1'b0; sp1 <= 1'b0; have_err <= 1'b0;
      last_idx <= '0; last_gap <= '0; streak <= '0;
    end else if (clr) begin
      lfsr <= '0; seed_n <= '0; seeded <= 1'b0; run <= '0; pos <= '0;
      locked <= 1'b0; done <= 1'b0; err_bit <= 1'b0;
      bit_cnt <= '0; err_cnt <= '0; rand_cnt <= '0; burst_cnt <= '0;
      burst_flag <= 1'b0; per_flag <= 1'b0; per_gap <= '0; pass_cnt <= '0;
      e1 <= 1'b0; e2 <= 1'b0; sp1 <= 1'b0; have_err <= 1'b0;
      last_idx <= '0; last_gap <= '0; streak <= '0;
    end else begin
      err_bit <= cmp && miss;
      if (seeding) begin
        lfsr <= {lfsr[29:0], in_bit};
        seed_n <= seed_n + 5'd1;
        if (seed_n == 5'd30) seeded <= 1'b1;
      end
      if (hunt) begin
        if (!cfg_mem_mode) lfsr <= {lfsr[29:0], in_bit};
        if (!miss) begin
          run <= run + RUN_W'(1);
          if (cfg_mem_mode) pos <= pos_next;
          if (run_full) begin
            locked <= 1'b1;
            if (!cfg_mem_mode) pos <= '0;
          end
        end else if (cfg_mem_mode && m0) begin
          run <= RUN_W'(1);
          pos <= (len32 == 32'd1) ? 32'd0 : 32'd1;
        end else begin
          run <= '0;
          if (cfg_mem_mode) pos <= '0;
        end
      end
      if (cmp) begin
        if (!cfg_mem_mode) lfsr <= {lfsr[29:0], prbs_ref};
        pos <= pos_next;
        bit_cnt <= (&bit_cnt) ? bit_cnt : bit_cnt + BIT_W'(1);
        if (at_last) begin
          pass_cnt <= (&pass_cnt) ? pass_cnt : pass_cnt + PASS_W'(1);
          if (cfg_passes != '0 && pass_cnt + PASS_W'(1) == cfg_passes) done <= 1'b1;
        end
        e1 <= miss;
        e2 <= e1;
        sp1 <= miss && same;
        if (miss) begin
          err_cnt <= (&err_cnt) ? err_cnt : err_cnt + ERR_W'(1);
          last_idx <= bit_cnt;
          have_err <= 1'b1;
          last_gap <= have_err ? gap : '0;
          streak <= new_streak;
        end
        if (burst_hit) begin
          burst_cnt <= (&burst_cnt) ? burst_cnt : burst_cnt + ERR_W'(1);
          burst_flag <= 1'b1;
        end
        if (rand_hit) rand_cnt <= (&rand_cnt) ? rand_cnt : rand_cnt + ERR_W'(1);
        if (per_hit) begin
          per_flag <= 1'b1;
          per_gap <= gap;
        end
      end
    end
  end

  p_err_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    err_bit |-> locked && err_cnt != '0);
  p_lock_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !clr) |=> locked);
  p_unlocked_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !clr) |=> $stable(bit_cnt) && $stable(err_cnt));
  p_burst_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_flag && !clr) |=> burst_flag && burst_cnt != '0);
  p_rand_le_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rand_cnt <= err_cnt);
  p_per_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    per_flag |-> per_gap >= BIT_W'(2));
  p_done_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> done && $stable(bit_cnt) && $stable(err_cnt) && $stable(pass_cnt));
  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> bit_cnt >= $past(bit_cnt) && err_cnt >= $past(err_cnt) && burst_cnt >= $past(burst_cnt));
  p_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !locked && !done && bit_cnt == '0 && err_cnt == '0 && !per_flag);
endmodule

// File: tb/sim_prbs_err_classifier.sv
module sim_prbs_err_classifier;
  localparam int TCLK = 10;
  localparam int EW = 8;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, in_vld = 1'b0, in_bit = 1'b0;
  logic cfg_mem_mode = 1'b0;
  logic [10:0] cfg_pat_len = 11'd40;
  logic [3:0] cfg_per_k = 4'd0;
  logic [9:0] cfg_passes = 10'd0;
  logic pat_we = 1'b0, pat_wbit = 1'b0;
  logic [9:0] pat_addr = '0;
  logic err_bit, locked, done, burst_flag, per_flag;
  logic [47:0] bit_cnt, per_gap;
  logic [EW-1:0] err_cnt, rand_cnt, burst_cnt;
  logic [9:0] pass_cnt;

  int total = 0, bad = 0, cyc = 0;
  logic [30:0] h;
  bit pl[256];
  bit pat[1024];
  int n;
  int x_err, x_burst, x_rand, x_gap;
  bit x_per;

  prbs_err_classifier #(.ERR_W(EW)) u0 (
    .clk, .rst_n, .clr, .in_vld, .in_bit, .cfg_mem_mode, .cfg_pat_len,
    .cfg_per_k, .cfg_passes, .pat_we, .pat_addr, .pat_wbit, .err_bit,
    .locked, .done, .bit_cnt, .err_cnt, .rand_cnt, .burst_cnt,
    .burst_flag, .per_flag, .per_gap, .pass_cnt);

  always #(TCLK/2) clk = ~clk;

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(bit b);
    in_vld = 1'b1; in_bit = b;
    @(negedge clk);
    in_vld = 1'b0;
  endtask

  task automatic pulse_clr();
    clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  task automatic gen(output bit b);
    b = h[30] ^ h[27];
    h = {h[29:0], b};
  endtask

  task automatic prbs_lock();
    bit b;
    h = 31'($urandom) | 31'd1;
    for (int i = 0; i < 95; i++) begin gen(b); send(b); end
  endtask

  task automatic prbs_payload();
    bit b;
    for (int i = 0; i < n; i++) begin gen(b); send(b ^ pl[i]); end
  endtask

  task automatic expect_cls(int k);
    int p1, g1, st, g;
    bit have;
    int kk;
    kk = (k == 0) ? 3 : k;
    x_err = 0; x_burst = 0; x_rand = 0; x_per = 0; x_gap = 0;
    have = 0; p1 = 0; g1 = 0; st = 0;
    for (int i = 0; i < n; i++) begin
      if (pl[i]) begin
        bit spaced;
        x_err++;
        if (i >= 1 && pl[i-1] && (i < 2 || !pl[i-2])) x_burst++;
        g = have ? i - p1 : 0;
        spaced = have && g >= 2 && g == g1;
        if (spaced) st++; else st = (have && g >= 2) ? 1 : 0;
        if (!x_per && have && g >= 2 && st >= kk) begin x_per = 1; x_gap = g; end
        if ((i == 0 || !pl[i-1]) && i + 1 < n && !pl[i+1] && !spaced) x_rand++;
        g1 = g; p1 = i; have = 1;
      end
    end
  endtask

  task automatic check_cls(string tag);
    chk({tag, " R4 bit_cnt"}, bit_cnt, n);
    chk({tag, " R4 err_cnt"}, err_cnt, x_err);
    chk({tag, " R5 burst_cnt"}, burst_cnt, x_burst);
    chk({tag, " R5 burst_flag"}, burst_flag, x_burst != 0);
    chk({tag, " R6 rand_cnt"}, rand_cnt, x_rand);
    chk({tag, " R7 per_flag"}, per_flag, x_per);
    chk({tag, " R7 per_gap"}, per_gap, x_gap);
  endtask

  initial begin
    while (cyc < 200000) begin @(posedge clk); cyc++; end
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=<200000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit b;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 locked", locked, 0);
    chk("R11 bit_cnt", bit_cnt, 0);
    chk("R11 err_cnt", err_cnt, 0);
    chk("R11 flags", {burst_flag, per_flag, done, err_bit}, 0);

    // R2 lock boundary
    h = 31'h1234567;
    for (int i = 0; i < 94; i++) begin gen(b); send(b); end
    chk("R2 not locked at 94", locked, 0);
    gen(b); send(b);
    chk("R2 locked at 95", locked, 1);
    gen(b); send(~b);
    chk("R1 err_bit on mismatch", err_bit, 1);
    gen(b); send(b);
    chk("R1 err_bit on match", err_bit, 0);

    // R7 periodic, K default and K=4
    for (int k = 0; k <= 4; k += 4) begin
      pulse_clr();
      cfg_per_k = 4'(k);
      n = 60;
      for (int i = 0; i < n; i++) pl[i] = (i == 10 || i == 17 || i == 24 || i == 31);
      prbs_lock();
      prbs_payload();
      expect_cls(k);
      check_cls(k == 0 ? "periodic k0" : "periodic k4");
    end

    // R5 R6 R7 random trials
    cfg_per_k = 4'd0;
    for (int t = 0; t < 10; t++) begin
      pulse_clr();
      cfg_per_k = 4'($urandom % 4);
      n = 80 + int'($urandom % 100);
      for (int i = 0; i < n; i++) pl[i] = (i < n - 4) && ($urandom % 7 == 0);
      prbs_lock();
      chk("R2 lock before payload", locked, 1);
      prbs_payload();
      expect_cls(cfg_per_k);
      check_cls("random trial");
    end

    // R10 clear
    pulse_clr();
    chk("R10 locked", locked, 0);
    chk("R10 bit_cnt", bit_cnt, 0);
    chk("R10 counters", {err_cnt, rand_cnt, burst_cnt}, 0);
    chk("R10 flags", {burst_flag, per_flag, done}, 0);

    // R3 pattern mode
    cfg_mem_mode = 1'b1; cfg_pat_len = 11'd40; cfg_passes = 10'd0;
    for (int a = 0; a < 40; a++) begin
      pat[a] = 1'($urandom);
      pat_we = 1'b1; pat_addr = 10'(a); pat_wbit = pat[a];
      @(negedge clk);
    end
    pat_we = 1'b0;
    pulse_clr();
    for (int s = 0; s < 63; s++) send(pat[s % 40]);
    chk("R3 not locked at 63", locked, 0);
    send(pat[63 % 40]);
    chk("R3 locked at 64", locked, 1);
    // R9 saturation: every bit wrong
    for (int s = 64; s < 364; s++) send(~pat[s % 40]);
    chk("R9 err_cnt saturates", err_cnt, 255);
    chk("R9 bit_cnt", bit_cnt, 300);
    chk("R5 one long burst", burst_cnt, 1);
    chk("R6 no random in burst", rand_cnt, 0);
    chk("R7 gap one not periodic", per_flag, 0);
    chk("R8 unlimited passes", done, 0);
    chk("R3 pass count on wrap", pass_cnt, 8);

    // R8 passes with burst at the final position
    cfg_passes = 10'd3;
    pulse_clr();
    for (int s = 0; s < 180; s++) send(pat[s % 40] ^ (s == 158 || s == 159));
    chk("R8 done", done, 1);
    chk("R8 pass_cnt", pass_cnt, 3);
    chk("R8 bit_cnt frozen", bit_cnt, 96);
    chk("R8 err_cnt at end", err_cnt, 2);
    chk("R8 R5 burst at end", burst_cnt, 1);
    chk("R8 R6 rand at end", rand_cnt, 0);
    send(~pat[180 % 40]);
    chk("R8 R1 no err_bit after done", err_bit, 0);
    chk("R8 err_cnt unchanged", err_cnt, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule